// File: doc/BRIEF.md
# Frame-Synchronous Interrupt Generator

This block gives the processor a periodic interrupt locked to the display raster. It counts scan lines from a one-cycle line strobe. A separate frame-start strobe marks the start of frame flyback and re-aligns the count. The frame is 312 lines long. The interrupt fires six times per frame, which is 300 per second at a 50 Hz frame rate. The first one comes two lines after flyback begins, and the rest follow at 52-line spacing.

Software reads a single status byte. One bit tells whether the raster is in flyback, and a 4-bit field counts interrupts that have not been serviced. A read strobe on that byte acknowledges everything pending and drops the request. The request is a level signal: it stays high while the count is non-zero. The flyback bit depends only on the raster position. Two reads in a row therefore see the same flyback value, which lets software confirm flyback by reading twice.

Top module: `frame_irq_gen`

## Requirements
- R1: After reset the line index is 0, the flyback flag is set, the pending count is 0, the status byte reads 0x40 and `irq_o` is low.
- R2: Each `line_stb_i` advances the line index by one. The index wraps from 311 back to 0.
- R3: The first interrupt of a frame is counted on the line strobe that moves the index to line 2, which is the second line strobe after frame start.
- R4: Further interrupts are counted as the index enters lines 54, 106, 158, 210 and 262, giving six per frame.
- R5: Status bit 6 is 1 while the line index is below 8 and 0 otherwise. Status bits 7, 5 and 4 are always 0.
- R6: Status bits 3:0 hold the number of unserviced interrupts. The count saturates at 15.
- R7: A `stat_rd_i` pulse clears the pending count. `irq_o` is high exactly while the count is non-zero.
- R8: When a read and a new interrupt fall in the same cycle, the count becomes 1, so the new interrupt is not lost.
- R9: `frame_stb_i` sets the line index to 0 and takes priority over a line strobe in the same cycle. Neither the frame strobe nor the pending count is affected by the other, and the frame strobe never counts an interrupt.
- R10: Reads of the status byte never change bit 6, so back-to-back reads show the same flyback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb_i | input | 1 | One-cycle pulse per scan line |
| frame_stb_i | input | 1 | One-cycle pulse at start of frame flyback |
| stat_rd_i | input | 1 | Status byte read; acknowledges pending interrupts |
| irq_o | output | 1 | Level interrupt request |
| status_o | output | 8 | Bit 6 flyback flag, bits 3:0 pending count, others 0 |

## Verification
The properties assume that the strobes are synchronous single-cycle pulses. They also assume that a frame strobe, when one is supplied, arrives at a line index where re-aligning to line 0 is meant; they do not demand that it coincide with the wrap. Relations involving the line index are checked only across the cycle that follows a strobe. The stimulus drives every input on the falling edge and holds each pulse for exactly one cycle. It includes one case each where a line strobe coincides with a read and where it coincides with a frame strobe, so the priority rules are covered without ever producing overlapping multi-cycle pulses.

// File: rtl/fsig_pkg.sv
package fsig_pkg;

  localparam int PEND_W   = 4;
  localparam int FLY_BIT  = 6;
  localparam int STAT_W   = 8;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic              fly,
    input logic [PEND_W-1:0] pend
  );
    logic [STAT_W-1:0] s;
    s          = '0;
    s[FLY_BIT] = fly;
    s[PEND_W-1:0] = pend;
    return s;
  endfunction

endpackage

// File: rtl/fsig_line_track.sv
module fsig_line_track #(
  parameter int SPACING = 52,
  parameter int COUNT   = 6,
  parameter int FIRST   = 2,
  parameter int FLY     = 8,
  localparam int LINES  = SPACING * COUNT,
  localparam int LW     = $clog2(LINES),
  localparam int PW     = $clog2(SPACING)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_stb,
  input  logic          frame_stb,
  output logic          fire,
  output logic          flyback,
  output logic [LW-1:0] line_idx
);

  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);
  localparam logic [LW-1:0] FLY_END   = LW'(FLY);
  localparam logic [PW-1:0] PH_LAST   = PW'(SPACING - 1);
  localparam logic [PW-1:0] PH_START  = PW'((SPACING - FIRST) % SPACING);

  logic [LW-1:0] line_q, line_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          adv_en;

  // next-state
  always_comb begin
    line_d = line_q;
    ph_d   = ph_q;
    fire   = 1'b0;
    adv_en = frame_stb | line_stb;
    if (frame_stb) begin
      line_d = '0;
      ph_d   = PH_START;
    end else if (line_stb) begin
      line_d = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
      ph_d   = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      fire   = (ph_q == PH_LAST);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      ph_q   <= PH_START;
    end else if (adv_en) begin
      line_q <= line_d;
      ph_q   <= ph_d;
    end
  end

  assign flyback  = (line_q < FLY_END);
  assign line_idx = line_q;

endmodule

// File: rtl/fsig_pend_cnt.sv
module fsig_pend_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] count,
  output logic          req
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d, base;
  logic          cnt_en;

  // next-state: clear first, then add the new event
  always_comb begin
    cnt_en = inc | clr;
    base   = clr ? '0 : cnt_q;
    cnt_d  = base;
    if (inc && (base != CMAX)) cnt_d = base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign req   = |cnt_q;

endmodule

// File: rtl/frame_irq_gen.sv
module frame_irq_gen
  import fsig_pkg::*;
#(
  parameter int SPACING = 52,
  parameter int COUNT   = 6,
  parameter int FIRST   = 2,
  parameter int FLY     = 8,
  localparam int LW     = $clog2(SPACING * COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb_i,
  input  logic              frame_stb_i,
  input  logic              stat_rd_i,
  output logic              irq_o,
  output logic [STAT_W-1:0] status_o
);

  logic              fire;
  logic              flyback;
  logic [LW-1:0]     line_idx;
  logic [PEND_W-1:0] pend;

  fsig_line_track #(
    .SPACING (SPACING),
    .COUNT   (COUNT),
    .FIRST   (FIRST),
    .FLY     (FLY)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_stb  (line_stb_i),
    .frame_stb (frame_stb_i),
    .fire      (fire),
    .flyback   (flyback),
    .line_idx  (line_idx)
  );

  fsig_pend_cnt #(
    .CW (PEND_W)
  ) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (fire),
    .clr   (stat_rd_i),
    .count (pend),
    .req   (irq_o)
  );

  assign status_o = pack_status(flyback, pend);

endmodule

// File: rtl/frame_irq_gen_chk.sv
module frame_irq_gen_chk #(
  parameter int SPACING = 52,
  parameter int COUNT   = 6,
  parameter int FIRST   = 2,
  parameter int LW      = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_stb_i,
  input logic          frame_stb_i,
  input logic          stat_rd_i,
  input logic          irq_o,
  input logic [7:0]    status_o,
  input logic          fire,
  input logic [LW-1:0] line_idx
);

  localparam int LINES = SPACING * COUNT;

  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb_i && !frame_stb_i && int'(line_idx) == LINES - 1) |=> (line_idx == '0));

  // R4
  fire_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((int'(line_idx) + SPACING - FIRST) % SPACING == 0));

  // R5
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7] == 1'b0) && (status_o[5:4] == 2'b00));

  // R6
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_i |=> (status_o[3:0] >= $past(status_o[3:0])));

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:0] == 4'hF && !stat_rd_i) |=> (status_o[3:0] == 4'hF));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !fire) |=> (status_o[3:0] == 4'h0 && !irq_o));

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (status_o[3:0] != 4'h0));

  // R8
  ack_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && fire) |=> (status_o[3:0] == 4'h1));

  // R9
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_i |=> (line_idx == '0 && status_o[6]));

  // R9
  frame_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_i |-> !fire);

  // R10
  fly_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb_i && !frame_stb_i) |=> $stable(status_o[6]));

endmodule

bind frame_irq_gen frame_irq_gen_chk #(
  .SPACING (SPACING),
  .COUNT   (COUNT),
  .FIRST   (FIRST),
  .LW      (LW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_stb_i  (line_stb_i),
  .frame_stb_i (frame_stb_i),
  .stat_rd_i   (stat_rd_i),
  .irq_o       (irq_o),
  .status_o    (status_o),
  .fire        (fire),
  .line_idx    (line_idx)
);

// File: tb/test_frame_irq_gen.sv
module test_frame_irq_gen;

  logic       clk;
  logic       rst_n;
  logic       line_stb;
  logic       frame_stb;
  logic       stat_rd;
  logic       irq;
  logic [7:0] status;

  int n_chk;
  int n_err;

  frame_irq_gen i_frame_irq_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_stb_i  (line_stb),
    .frame_stb_i (frame_stb),
    .stat_rd_i   (stat_rd),
    .irq_o       (irq),
    .status_o    (status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [11:0] nstb;
    logic        frm;
    logic        rd;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  // line strobes, then optional frame strobe, check, then optional read
  localparam vec_t VECS [13] = '{
    '{12'd1,   1'b0, 1'b0, 8'h40, 4'd2},  // R2 line 1
    '{12'd1,   1'b0, 1'b1, 8'h41, 4'd3},  // R3 line 2 first irq
    '{12'd5,   1'b0, 1'b0, 8'h40, 4'd5},  // R5 line 7 still flyback
    '{12'd1,   1'b0, 1'b0, 8'h00, 4'd5},  // R5 line 8 flyback over
    '{12'd46,  1'b0, 1'b0, 8'h01, 4'd4},  // R4 line 54
    '{12'd52,  1'b0, 1'b0, 8'h02, 4'd4},  // R4 line 106
    '{12'd52,  1'b0, 1'b1, 8'h03, 4'd4},  // R4 line 158
    '{12'd104, 1'b0, 1'b1, 8'h02, 4'd4},  // R4 lines 210, 262
    '{12'd50,  1'b0, 1'b0, 8'h40, 4'd2},  // R2 wrap to 0
    '{12'd2,   1'b0, 1'b1, 8'h41, 4'd3},  // R3 next frame
    '{12'd10,  1'b0, 1'b0, 8'h00, 4'd5},  // R5 line 12
    '{12'd0,   1'b1, 1'b0, 8'h40, 4'd9},  // R9 frame strobe realigns
    '{12'd2,   1'b0, 1'b1, 8'h41, 4'd9}   // R9 irq two lines after
  };

  task automatic check(input string tag, input logic [7:0] exp);
    logic exp_irq;
    exp_irq = (exp[3:0] != 4'h0);
    n_chk++;
    if (status !== exp || irq !== exp_irq) begin
      n_err++;
      $display("FAIL %s: status=%02h irq=%0b expected status=%02h irq=%0b",
               tag, status, irq, exp, exp_irq);
    end
  endtask

  task automatic pulse(input logic ls, input logic fs, input logic rd);
    @(negedge clk);
    line_stb  = ls;
    frame_stb = fs;
    stat_rd   = rd;
    @(negedge clk);
    line_stb  = 1'b0;
    frame_stb = 1'b0;
    stat_rd   = 1'b0;
  endtask

  task automatic lines(input int n);
    for (int k = 0; k < n; k++) pulse(1'b1, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] fly_a;
    n_chk     = 0;
    n_err     = 0;
    rst_n     = 1'b0;
    line_stb  = 1'b0;
    frame_stb = 1'b0;
    stat_rd   = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 8'h40);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 8'h40);

    for (int v = 0; v < 13; v++) begin
      lines(int'(VECS[v].nstb));
      if (VECS[v].frm) pulse(1'b0, 1'b1, 1'b0);
      check($sformatf("vec %0d R%0d", v, VECS[v].req), VECS[v].exp);
      if (VECS[v].rd) begin
        pulse(1'b0, 1'b0, 1'b1);
        check($sformatf("vec %0d R7 ack", v), VECS[v].exp & 8'h40);
      end
    end

    // R6 saturation: three full frames unserviced from line 2
    lines(936);
    check("R6 saturate at 15", 8'h4F);
    lines(52);
    check("R6 hold at 15", 8'h0F);

    // R9 frame strobe leaves pending count alone
    pulse(1'b0, 1'b1, 1'b0);
    check("R9 frame keeps count", 8'h4F);

    // R10 back-to-back reads see the same flyback bit
    pulse(1'b0, 1'b0, 1'b1);
    fly_a = status;
    check("R7 read clears", 8'h40);
    pulse(1'b0, 1'b0, 1'b1);
    n_chk++;
    if (status[6] !== fly_a[6] || status[6] !== 1'b1) begin
      n_err++;
      $display("FAIL R10: bit6=%0b expected %0b", status[6], fly_a[6]);
    end

    // R8 read and interrupt in the same cycle
    lines(53);
    check("R8 setup line 53", 8'h01);
    pulse(1'b0, 1'b0, 1'b1);
    check("R8 setup cleared", 8'h00);
    pulse(1'b1, 1'b0, 1'b1);
    check("R8 race keeps new irq", 8'h01);

    // R9 frame wins over line strobe
    pulse(1'b1, 1'b1, 1'b0);
    check("R9 frame priority", 8'h41);
    lines(1);
    check("R9 line 1 after frame", 8'h41);
    lines(1);
    check("R3 line 2 after frame", 8'h42);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", 8'h40);
    rst_n = 1'b1;
    lines(2);
    check("R3 after mid-run reset", 8'h41);

    finish_run();
  end

endmodule